// File: doc/BRIEF.md
# SPI Master Port with Transmit and Receive Queues

This block is a synchronous serial port that always acts as the SPI master. Software controls it through a simple 32-bit register bus with word-aligned offsets inside a 4 KB window. Frames written to the data register go into an 8-entry transmit queue. The shift engine takes them out one at a time, drives them MSB first on `mosi` and holds `cs_n` low. At the same time it collects the same number of bits from `miso` into an 8-entry receive queue, which is drained by reading the data register.

The serial clock comes from a two-stage divider: an even prescale value (2 to 254) multiplied by one plus an 8-bit rate factor. Clock polarity and phase are both selectable. Frames that follow each other with no gap keep `cs_n` asserted. A status register reports queue levels and activity, and a set of read-only bytes at the top of the window identifies the block.

The engine is a three-state machine. `ST_IDLE` means chip select is high and the clock is parked. `ST_LEAD` is the first half of a bit. `ST_TRAIL` is the second half of a bit. The transitions are:
- idle→lead (start): enabled and the transmit queue holds data; pop a frame.
- lead→trail (sample): the half-period count expires; `miso` is captured.
- trail→lead (shift): bits remain, or the frame ended and another frame is queued while enabled.
- trail→idle (finish): the frame ended and nothing more can start.

Top module: `ssp_master`

## Requirements
- R1: Offset 0x000 (control 0) reads back all 16 written bits. Offset 0x004 (control 1) keeps only bit 1, the port enable. Any offset that is not mapped reads zero.
- R2: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x22, 0x10, 0x24 and 0x00. Offsets 0xFF0 to 0xFFC read 0x0D, 0xF0, 0x05 and 0xB1.
- R3: Offset 0x010 (prescale) stores bits 7:0 of the write data with bit 0 forced to zero. Writing 5 reads back 4, and writing 0x1FF reads back 0xFE.
- R4: Offset 0x00C (status) has five flags: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. After reset it reads 0x03.
- R5: Control 0 bits 3:0 give the frame size as value+1 bits; values below 3 count as 3. Frames go out MSB first, and the received frame reads back right-justified with zeros above it.
- R6: `sclk` idles at control 0 bit 6. With control 0 bit 7 clear, `miso` is sampled on the first clock edge of each bit. With bit 7 set, it is sampled on the second edge.
- R7: One `sclk` period is P×(1+S) clock cycles, where P is the prescale value and S is control 0 bits 15:8. A prescale below 2 counts as 2.
- R8: `cs_n` falls when a frame starts. It stays low across frames that follow each other with no gap, and it rises only after the last queued frame.
- R9: The transmit queue holds 8 frames. A write to the data register while the queue is full is dropped.
- R10: The receive queue holds 8 frames. A frame received while it is full is lost, and the stored frames are kept.
- R11: Reading the data register while the receive queue is empty returns zero and leaves the status unchanged.
- R12: While the enable is clear no frame starts. Clearing the enable during a frame lets that frame finish.
- R13: Busy is set whenever the transmit queue is not empty or a frame is being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; pops the receive queue at offset 0x008 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_addr` is presented |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
The checker assumes that the mode, size, rate factor and prescale bits do not change while a frame is shifting. It also assumes that `bus_wr` and `bus_rd` are single-cycle strobes that are never raised together. Without these, the idle-level and queue-bound properties could be broken by the stimulus rather than by the design. The bench changes configuration only after polling the busy flag clear. It drives each strobe for exactly one cycle between falling edges. It moves `miso` only right after a sampling edge, so the captured bit is always stable at the edge where the engine samples.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int DATA_W     = 16;
    localparam int Q_DEPTH    = 8;
    localparam int RATE_W     = 8;
    localparam int ADDR_W     = 12;
    localparam int BUS_W      = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL0  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL1  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_PSC    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_PID0   = 12'hFE0;
    localparam logic [ADDR_W-1:0] OFS_PID1   = 12'hFE4;
    localparam logic [ADDR_W-1:0] OFS_PID2   = 12'hFE8;
    localparam logic [ADDR_W-1:0] OFS_PID3   = 12'hFEC;
    localparam logic [ADDR_W-1:0] OFS_CID0   = 12'hFF0;
    localparam logic [ADDR_W-1:0] OFS_CID1   = 12'hFF4;
    localparam logic [ADDR_W-1:0] OFS_CID2   = 12'hFF8;
    localparam logic [ADDR_W-1:0] OFS_CID3   = 12'hFFC;

    localparam logic [7:0] PID0_VAL = 8'h22;
    localparam logic [7:0] PID1_VAL = 8'h10;
    localparam logic [7:0] PID3_VAL = 8'h00;
    localparam logic [7:0] CID0_VAL = 8'h0D;
    localparam logic [7:0] CID1_VAL = 8'hF0;
    localparam logic [7:0] CID2_VAL = 8'h05;
    localparam logic [7:0] CID3_VAL = 8'hB1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL
    } eng_state_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
#(
    parameter int FW = DATA_W,
    parameter int RW = RATE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    cpol,
    input  logic                    cpha,
    input  logic [$clog2(FW)-1:0]   dss,
    input  logic [RW-1:0]           scr,
    input  logic [RW-1:0]           cpsr,
    input  logic                    tx_empty,
    input  logic [FW-1:0]           tx_word,
    output logic                    tx_pop,
    output logic                    rx_push,
    output logic [FW-1:0]           rx_word,
    output logic                    active,
    output logic                    sclk,
    output logic                    mosi,
    output logic                    cs_n,
    input  logic                    miso
);
    localparam int SW = $clog2(FW);
    localparam int BW = $clog2(FW + 1);
    localparam int CW = 2 * RW;

    eng_state_t     st_q, st_d;
    logic [CW-1:0]  cnt_q, half_len, pre_eff;
    logic [BW-1:0]  bits_q, width;
    logic [FW-1:0]  tx_sr, rx_sr;
    logic           half_done, last_bit, more, load;

    // half period in clock cycles: (prescale/2) * (1 + rate factor)
    always_comb begin
        pre_eff  = (cpsr[RW-1:1] == '0) ? CW'(1) : CW'(cpsr[RW-1:1]);
        half_len = pre_eff * (CW'(scr) + CW'(1));
        width    = (dss < SW'(3)) ? BW'(4) : BW'(dss) + BW'(1);
    end

    assign half_done = (cnt_q >= half_len - CW'(1));
    assign last_bit  = (bits_q == BW'(1));
    assign more      = enable && !tx_empty;
    assign load      = ((st_q == ST_IDLE) && more) ||
                       ((st_q == ST_TRAIL) && half_done && last_bit && more);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (more) st_d = ST_LEAD;
            ST_LEAD:  if (half_done) st_d = ST_TRAIL;
            ST_TRAIL: if (half_done) st_d = (last_bit && !more) ? ST_IDLE : ST_LEAD;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bits_q <= '0;
            tx_sr  <= '0;
            rx_sr  <= '0;
        end else begin
            cnt_q <= (st_q == ST_IDLE || half_done) ? '0 : cnt_q + CW'(1);
            if (load) begin
                tx_sr  <= tx_word << (BW'(FW) - width);
                rx_sr  <= '0;
                bits_q <= width;
            end else begin
                if (st_q == ST_LEAD && half_done)
                    rx_sr <= {rx_sr[FW-2:0], miso};
                if (st_q == ST_TRAIL && half_done) begin
                    tx_sr  <= tx_sr << 1;
                    bits_q <= bits_q - BW'(1);
                end
            end
        end
    end

    always_comb begin
        cs_n    = (st_q == ST_IDLE);
        active  = (st_q != ST_IDLE);
        sclk    = cpol ^ (cpha ? (st_q == ST_LEAD) : (st_q == ST_TRAIL));
        mosi    = (st_q != ST_IDLE) && tx_sr[FW-1];
        tx_pop  = load;
        rx_push = (st_q == ST_TRAIL) && half_done && last_bit;
        rx_word = rx_sr;
    end
endmodule

// File: rtl/ssp_master.sv
module ssp_master
    import ssp_pkg::*;
#(
    parameter int FW     = DATA_W,
    parameter int DEPTH  = Q_DEPTH,
    parameter logic [3:0] ID_REV = 4'h2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    input  logic               miso
);
    localparam int QCW = $clog2(DEPTH + 1);
    localparam int SW  = $clog2(FW);

    logic [15:0]        ctrl0_q;
    logic               enable_q;
    logic [RATE_W-1:0]  cpsr_q;

    logic               tx_wr, tx_pop, tx_empty, tx_full;
    logic               rx_pop, rx_push, rx_empty, rx_full;
    logic [FW-1:0]      tx_head, rx_head, rx_word;
    logic [QCW-1:0]     tx_count, rx_count;
    logic               active, busy;
    logic [4:0]         status;

    assign tx_wr  = bus_wr && (bus_addr == OFS_DATA);
    assign rx_pop = bus_rd && (bus_addr == OFS_DATA);
    assign busy   = !tx_empty || active;
    assign status = {busy, rx_full, !rx_empty, !tx_full, tx_empty};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_q  <= '0;
            enable_q <= 1'b0;
            cpsr_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL0) ctrl0_q  <= bus_wdata[15:0];
            if (bus_addr == OFS_CTRL1) enable_q <= bus_wdata[1];
            if (bus_addr == OFS_PSC)   cpsr_q   <= {bus_wdata[RATE_W-1:1], 1'b0};
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL0: bus_rdata = BUS_W'(ctrl0_q);
            OFS_CTRL1: bus_rdata = BUS_W'({enable_q, 1'b0});
            OFS_DATA:  bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
            OFS_STAT:  bus_rdata = BUS_W'(status);
            OFS_PSC:   bus_rdata = BUS_W'(cpsr_q);
            OFS_PID0:  bus_rdata = BUS_W'(PID0_VAL);
            OFS_PID1:  bus_rdata = BUS_W'(PID1_VAL);
            OFS_PID2:  bus_rdata = BUS_W'({ID_REV, 4'h4});
            OFS_PID3:  bus_rdata = BUS_W'(PID3_VAL);
            OFS_CID0:  bus_rdata = BUS_W'(CID0_VAL);
            OFS_CID1:  bus_rdata = BUS_W'(CID1_VAL);
            OFS_CID2:  bus_rdata = BUS_W'(CID2_VAL);
            OFS_CID3:  bus_rdata = BUS_W'(CID3_VAL);
            default:   bus_rdata = '0;
        endcase
    end

    ssp_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr), .wdata(bus_wdata[FW-1:0]),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full), .count(tx_count)
    );

    ssp_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_count)
    );

    ssp_engine #(.FW(FW), .RW(RATE_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(enable_q),
        .cpol(ctrl0_q[6]), .cpha(ctrl0_q[7]),
        .dss(ctrl0_q[SW-1:0]), .scr(ctrl0_q[15:8]), .cpsr(cpsr_q),
        .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .active(active),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk #(
    parameter int DEPTH = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sclk,
    input logic                         cs_n,
    input logic                         cpol,
    input logic                         enable,
    input logic                         busy,
    input logic                         tx_wr,
    input logic                         tx_pop,
    input logic                         tx_empty,
    input logic                         tx_full,
    input logic [$clog2(DEPTH+1)-1:0]   tx_count,
    input logic                         rx_push,
    input logic                         rx_pop,
    input logic                         rx_full,
    input logic [$clog2(DEPTH+1)-1:0]   rx_count
);
    localparam int QCW = $clog2(DEPTH + 1);

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cpol)); // R6

    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= QCW'(DEPTH)); // R9

    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_wr && !tx_pop) |=> (tx_full && $stable(tx_count))); // R9

    AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop) |=> (rx_count == QCW'(DEPTH))); // R10

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(enable && !tx_empty)); // R12

    AST_BUSY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy); // R13

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R8
endmodule

bind ssp_master ssp_master_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .cpol(ctrl0_q[6]), .enable(enable_q), .busy(busy),
    .tx_wr(tx_wr), .tx_pop(tx_pop), .tx_empty(tx_empty), .tx_full(tx_full),
    .tx_count(tx_count), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_full(rx_full), .rx_count(rx_count)
);

// File: tb/sim_ssp_master.sv
`timescale 1ns/1ps
module sim_ssp_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, cs_n;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    ssp_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // slave model
    logic [15:0] sl_q  [16];
    logic [15:0] cap_q [16];
    logic [15:0] cap;
    int  sl_rd, cap_wr, bit_cnt, bw, cs_rise;
    bit  b_cpol, b_cpha;
    realtime last_t, period;

    function automatic logic slave_bit();
        if (sl_rd < 16 && bit_cnt < bw) return sl_q[sl_rd][bw-1-bit_cnt];
        return 1'b0;
    endfunction

    always @(negedge cs_n) begin
        bit_cnt = 0;
        cap = '0;
        miso = slave_bit();
    end

    always @(posedge cs_n) cs_rise++;

    always @(sclk) begin
        if (cs_n === 1'b0 && sclk === (b_cpha ? b_cpol : ~b_cpol)) begin
            if (bit_cnt > 0) period = $realtime - last_t;
            last_t = $realtime;
            cap = {cap[14:0], mosi};
            bit_cnt++;
            if (bit_cnt == bw) begin
                if (cap_wr < 16) cap_q[cap_wr] = cap;
                cap_wr++;
                sl_rd++;
                bit_cnt = 0;
                cap = '0;
            end
            miso = slave_bit();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            bus_read(12'h00C, s);
            if (!s[4]) return;
        end
        chk("R13 busy never cleared", 32'h1, 32'h0);
    endtask

    task automatic slave_reset();
        for (int i = 0; i < 16; i++) begin sl_q[i] = '0; cap_q[i] = '0; end
        sl_rd = 0; cap_wr = 0; bit_cnt = 0; cap = '0;
    endtask

    task automatic set_mode(input bit pol, input bit pha, input int dss, input int scr);
        b_cpol = pol; b_cpha = pha;
        bw = (dss < 3) ? 4 : dss + 1;
        bus_write(12'h000, {16'h0, 8'(scr), pha, pol, 2'b00, 4'(dss)});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R4 reset cs_n", {31'h0, cs_n}, 32'h1);
        chk("R6 reset sclk idle", {31'h0, sclk}, 32'h0);
        bus_read(12'h00C, d); chk("R4 reset status", d, 32'h03);
        bus_read(12'h000, d); chk("R1 reset ctrl0", d, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_write(12'h000, 32'hFFFF_C3A7);
        bus_read(12'h000, d); chk("R1 ctrl0 readback", d, 32'hC3A7);
        bus_write(12'h004, 32'hFFFF_FFFD);
        bus_read(12'h004, d); chk("R1 ctrl1 keeps bit1 only", d, 32'h0);
        bus_write(12'h004, 32'h0000_0002);
        bus_read(12'h004, d); chk("R1 ctrl1 enable", d, 32'h2);
        bus_write(12'h004, 32'h0);
        bus_read(12'h014, d); chk("R1 unmapped 0x014", d, 32'h0);
        bus_read(12'h800, d); chk("R1 unmapped 0x800", d, 32'h0);
        bus_read(12'hFE0, d); chk("R2 id0", d, 32'h22);
        bus_read(12'hFE4, d); chk("R2 id1", d, 32'h10);
        bus_read(12'hFE8, d); chk("R2 id2", d, 32'h24);
        bus_read(12'hFEC, d); chk("R2 id3", d, 32'h00);
        bus_read(12'hFF0, d); chk("R2 cell0", d, 32'h0D);
        bus_read(12'hFF4, d); chk("R2 cell1", d, 32'hF0);
        bus_read(12'hFF8, d); chk("R2 cell2", d, 32'h05);
        bus_read(12'hFFC, d); chk("R2 cell3", d, 32'hB1);
        bus_write(12'h010, 32'h5);
        bus_read(12'h010, d); chk("R3 odd prescale", d, 32'h4);
        bus_write(12'h010, 32'h1FF);
        bus_read(12'h010, d); chk("R3 max prescale", d, 32'hFE);
        bus_write(12'h010, 32'h2);
        set_mode(0, 0, 7, 0);
    endtask

    task automatic xfer_one(input string req, input logic [15:0] tx, input logic [15:0] sl,
                            input logic [15:0] exp_mosi, input logic [15:0] exp_rx);
        logic [31:0] d;
        slave_reset();
        sl_q[0] = sl;
        bus_write(12'h008, {16'h0, tx});
        wait_idle();
        chk({req, " frames shifted"}, cap_wr, 32'd1);
        chk({req, " mosi frame"}, {16'h0, cap_q[0]}, {16'h0, exp_mosi});
        bus_read(12'h008, d);
        chk({req, " received frame"}, d, {16'h0, exp_rx});
    endtask

    task automatic t_modes();
        bus_write(12'h004, 32'h2);
        for (int m = 0; m < 4; m++) begin
            set_mode(m[0], m[1], 7, 1);
            repeat (2) @(negedge clk);
            chk("R6 idle sclk level", {31'h0, sclk}, {31'h0, m[0]});
            xfer_one("R6 mode", 16'h00A5 ^ 16'(m), 16'h003C + 16'(m),
                     16'h00A5 ^ 16'(m), 16'h003C + 16'(m));
        end
    endtask

    task automatic t_width();
        set_mode(0, 0, 15, 0);
        xfer_one("R5 16-bit", 16'hBEEF, 16'h1234, 16'hBEEF, 16'h1234);
        set_mode(1, 0, 3, 0);
        xfer_one("R5 4-bit", 16'h00FA, 16'h0005, 16'h000A, 16'h0005);
        set_mode(0, 1, 1, 0);
        xfer_one("R5 size below 3", 16'h0009, 16'h0006, 16'h0009, 16'h0006);
        set_mode(0, 0, 7, 0);
    endtask

    task automatic t_rate();
        logic [31:0] d;
        bus_write(12'h010, 32'h4);
        set_mode(0, 0, 7, 2);
        xfer_one("R7 divided", 16'h0081, 16'h0042, 16'h0081, 16'h0042);
        chk("R7 period 4x3 cycles", int'(period), 32'd60);
        bus_write(12'h010, 32'h0);
        set_mode(1, 1, 7, 0);
        xfer_one("R7 zero prescale", 16'h0011, 16'h0022, 16'h0011, 16'h0022);
        chk("R7 period floor 2 cycles", int'(period), 32'd10);
        bus_write(12'h010, 32'h2);
        set_mode(0, 0, 7, 0);
        bus_read(12'h010, d);
    endtask

    task automatic t_back2back();
        logic [31:0] d;
        slave_reset();
        sl_q[0] = 16'h11; sl_q[1] = 16'h22; sl_q[2] = 16'h33;
        cs_rise = 0;
        bus_write(12'h008, 32'hA1);
        bus_write(12'h008, 32'hA2);
        bus_write(12'h008, 32'hA3);
        bus_read(12'h00C, d); chk("R13 busy while shifting", {31'h0, d[4]}, 32'h1);
        wait_idle();
        chk("R8 single chip-select release", cs_rise, 32'd1);
        chk("R8 three frames", cap_wr, 32'd3);
        chk("R8 third mosi frame", {16'h0, cap_q[2]}, 32'hA3);
        for (int i = 0; i < 3; i++) begin
            bus_read(12'h008, d);
            chk("R8 received order", d, 32'h11 * (i + 1));
        end
    endtask

    task automatic t_queues();
        logic [31:0] d;
        bus_write(12'h004, 32'h0);
        slave_reset();
        for (int i = 0; i < 9; i++) sl_q[i] = 16'h40 + 16'(i);
        for (int i = 0; i < 9; i++) bus_write(12'h008, 32'h10 + i);
        bus_read(12'h00C, d); chk("R9 status with full tx queue", d, 32'h10);
        bus_write(12'h004, 32'h2);
        wait_idle();
        chk("R9 only eight frames sent", cap_wr, 32'd8);
        chk("R9 last kept frame", {16'h0, cap_q[7]}, 32'h17);
        bus_read(12'h00C, d); chk("R4 status rx full", d, 32'h0F);
        bus_write(12'h008, 32'h99);
        wait_idle();
        chk("R10 extra frame shifted", cap_wr, 32'd9);
        for (int i = 0; i < 8; i++) begin
            bus_read(12'h008, d);
            chk("R10 stored frames kept", d, 32'h40 + i);
        end
        bus_read(12'h00C, d); chk("R11 status drained", d, 32'h03);
        bus_read(12'h008, d); chk("R11 empty read value", d, 32'h0);
        bus_read(12'h00C, d); chk("R11 status unchanged", d, 32'h03);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(12'h004, 32'h0);
        slave_reset();
        sl_q[0] = 16'h66; sl_q[1] = 16'h77;
        bus_write(12'h008, 32'h5A);
        repeat (50) @(negedge clk);
        chk("R12 no start while disabled", {31'h0, cs_n}, 32'h1);
        bus_read(12'h00C, d); chk("R13 busy with queued frame", d, 32'h12);
        bus_write(12'h004, 32'h2);
        wait_idle();
        chk("R12 frame after enable", {16'h0, cap_q[0]}, 32'h5A);
        bus_read(12'h008, d); chk("R12 received after enable", d, 32'h66);
        set_mode(0, 0, 7, 3);
        bus_write(12'h008, 32'hC1);
        bus_write(12'h008, 32'hC2);
        repeat (8) @(negedge clk);
        bus_write(12'h004, 32'h0);
        for (int i = 0; i < 500 && cs_n !== 1'b1; i++) @(negedge clk);
        repeat (100) @(negedge clk);
        chk("R12 running frame finishes", cap_wr, 32'd2);
        bus_read(12'h00C, d); chk("R12 second frame held", {31'h0, d[0]}, 32'h0);
        bus_write(12'h004, 32'h2);
        wait_idle();
        chk("R12 held frame sent", {16'h0, cap_q[2]}, 32'hC2);
        for (int i = 0; i < 2; i++) bus_read(12'h008, d);
        set_mode(0, 0, 7, 0);
    endtask

    initial begin
        slave_reset();
        bw = 8; b_cpol = 0; b_cpha = 0; cs_rise = 0; last_t = 0; period = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_modes();
        t_width();
        t_rate();
        t_back2back();
        t_queues();
        t_enable();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule